// File: doc/BRIEF.md
# Binary Hit Comparator Output Logic

This block turns the over-threshold decisions of a bank of comparator channels into a prompt binary hit word, one word per bunch crossing, for use by a fast trigger. A crossing is marked by a one-cycle strobe. On every strobe the block samples the comparator levels, the operating mode and the per-channel mask. It then registers a hit word with a valid strobe. Between crossings the hit word is forced to zero, so a hit never lingers into a later crossing.

Two modes are offered. In track mode a channel reports a hit on every crossing at which its input is over threshold. In pulse mode a channel reports a hit that lasts one crossing. The channel is then dead for the following crossing, and during that crossing its input has no effect. A set mask bit silences its channel in both modes. The mode, the mask and each channel's dead flag are kept in three voted copies that are rewritten every cycle, so a single upset copy is outvoted and repaired. A control change is recognised at the crossing where it is first seen, by comparing the sampled mode and mask with the values applied at the previous crossing. Such a change cancels any pending dead crossing.

The hit word leaves as a valid-only stream. There is no ready and no back-pressure: crossings arrive at a fixed rate, and the consumer must take the word in the single cycle in which the valid strobe is high.

Top module: `bhc_top`

## Requirements
- R1: After reset, hit_o is all zero and hit_valid_o is low until the first crossing strobe.
- R2: hit_valid_o is high in exactly the cycle that follows a clock edge at which xing_i was high, and low in every other cycle.
- R3: hit_o is all zero whenever hit_valid_o is low, so no hit carries over past its crossing.
- R4: With mode_i = 0 (track), each hit bit equals the channel's over_thr_i AND NOT mask_i as sampled at the crossing, for as long as the level persists.
- R5: With mode_i = 1 (pulse), a channel that is not dead reports a hit when over_thr_i is high at the crossing, so an input held high gives hits on alternate crossings.
- R6: In pulse mode the crossing right after a channel's hit is dead for that channel: it reports no hit whatever its input, and the channel is live again at the crossing after that.
- R7: A channel whose mask_i bit is 1 never reports a hit, in either mode.
- R8: If mode_i or mask_i at a crossing differs from the value applied at the previous crossing, all pending dead crossings are cancelled for that crossing.
- R9: over_thr_i, mode_i and mask_i are ignored in cycles without a crossing strobe: activity confined to those cycles changes neither the hit word nor the channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| xing_i | input | 1 | One-cycle crossing strobe; inputs are sampled when high |
| over_thr_i | input | NUM_CH | Per-channel comparator over-threshold level |
| mode_i | input | 1 | 0 selects track mode, 1 selects pulse mode |
| mask_i | input | NUM_CH | Per-channel mask, 1 silences the channel |
| hit_o | output | NUM_CH | Registered hit word of the last crossing |
| hit_valid_o | output | 1 | High for the one cycle that hit_o carries a crossing |

## Verification
The properties take for granted that the comparator levels, mode and mask only matter when the crossing strobe is high. They also assume that a full reset comes before the first crossing, because they follow the previous crossing's control and hits from reset values. The stimulus changes inputs only on the falling clock edge and holds the crossing strobe for a single cycle. Inputs that toggle between crossings are used only in the scenario that tests that such activity is ignored.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic {
    BHC_TRACK = 1'b0,
    BHC_PULSE = 1'b1
  } bhc_mode_e;

  function automatic logic [0:0] vote_bit(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/bhc_tmr_reg.sv
module bhc_tmr_reg #(
  parameter int unsigned     W   = 1,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import bhc_pkg::*;

  localparam int unsigned COPIES = 3;

  logic [W-1:0] copy_q [COPIES];

  // each copy loads new data, otherwise takes the voted value back (scrub)
  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    copy_q[k] <= RST;
      else if (ld_i) copy_q[k] <= d_i;
      else           copy_q[k] <= q_o;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_vote
    assign q_o[b] = vote_bit(copy_q[0][b], copy_q[1][b], copy_q[2][b]);
  end

endmodule

// File: rtl/bhc_ctrl.sv
module bhc_ctrl #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_i,
  input  logic              mode_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              chg_o
);
  localparam int unsigned CW = NUM_CH + 1;

  logic [CW-1:0] cur_ctrl;
  logic [CW-1:0] held_ctrl;

  assign cur_ctrl = {mode_i, mask_i};

  // control applied at the previous crossing, reset to track mode, no mask
  bhc_tmr_reg #(.W(CW), .RST('0)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (xing_i),
    .d_i   (cur_ctrl),
    .q_o   (held_ctrl)
  );

  assign chg_o = (cur_ctrl != held_ctrl);

endmodule

// File: rtl/bhc_lane.sv
module bhc_lane
  import bhc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xing_i,
  input  logic      ovt_i,
  input  logic      mask_i,
  input  bhc_mode_e mode_i,
  input  logic      chg_i,
  output logic      hit_o
);
  logic dead_q;
  logic dead_d;
  logic live;

  assign live   = (mode_i == BHC_TRACK) || !dead_q || chg_i;
  assign hit_o  = ovt_i && !mask_i && live;
  assign dead_d = (mode_i == BHC_PULSE) && hit_o;

  bhc_tmr_reg #(.W(1), .RST(1'b0)) u_dead (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (xing_i),
    .d_i   (dead_d),
    .q_o   (dead_q)
  );

endmodule

// File: rtl/bhc_outreg.sv
module bhc_outreg #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_i,
  input  logic [NUM_CH-1:0] hits_i,
  output logic [NUM_CH-1:0] hit_o,
  output logic              valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      hit_o   <= xing_i ? hits_i : '0;
      valid_o <= xing_i;
    end
  end

endmodule

// File: rtl/bhc_top.sv
module bhc_top
  import bhc_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_i,
  input  logic [NUM_CH-1:0] over_thr_i,
  input  logic              mode_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [NUM_CH-1:0] hit_o,
  output logic              hit_valid_o
);
  bhc_mode_e         mode_e;
  logic              ctrl_chg;
  logic [NUM_CH-1:0] lane_hit;

  assign mode_e = bhc_mode_e'(mode_i);

  bhc_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .xing_i (xing_i),
    .mode_i (mode_i),
    .mask_i (mask_i),
    .chg_o  (ctrl_chg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    bhc_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .xing_i (xing_i),
      .ovt_i  (over_thr_i[c]),
      .mask_i (mask_i[c]),
      .mode_i (mode_e),
      .chg_i  (ctrl_chg),
      .hit_o  (lane_hit[c])
    );
  end

  bhc_outreg #(.NUM_CH(NUM_CH)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .xing_i  (xing_i),
    .hits_i  (lane_hit),
    .hit_o   (hit_o),
    .valid_o (hit_valid_o)
  );

endmodule

// File: rtl/bhc_top_chk.sv
module bhc_top_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xing_i,
  input logic [NUM_CH-1:0] over_thr_i,
  input logic              mode_i,
  input logic [NUM_CH-1:0] mask_i,
  input logic [NUM_CH-1:0] hit_o,
  input logic              hit_valid_o
);
  // observed view of the current and previous crossing, built from ports
  logic              cur_mode, prv_mode;
  logic [NUM_CH-1:0] cur_mask, prv_mask, cur_ovt, last_hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode  <= 1'b0;
      prv_mode  <= 1'b0;
      cur_mask  <= '0;
      prv_mask  <= '0;
      cur_ovt   <= '0;
      last_hits <= '0;
    end else begin
      if (xing_i) begin
        cur_mode <= mode_i;
        cur_mask <= mask_i;
        cur_ovt  <= over_thr_i;
        prv_mode <= cur_mode;
        prv_mask <= cur_mask;
      end
      if (hit_valid_o) last_hits <= hit_o;
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xing_i |=> hit_valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xing_i |=> !hit_valid_o);
  assert_no_spill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid_o |-> (hit_o == '0));
  assert_track_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid_o && !cur_mode) |-> (hit_o == (cur_ovt & ~cur_mask)));
  assert_hit_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid_o |-> ((hit_o & ~cur_ovt) == '0));
  assert_dead_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid_o && cur_mode && prv_mode && (cur_mask == prv_mask))
      |-> (hit_o == (cur_ovt & ~cur_mask & ~last_hits)));
  assert_mask_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid_o |-> ((hit_o & cur_mask) == '0));
  assert_chg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid_o && cur_mode && ((cur_mode != prv_mode) || (cur_mask != prv_mask)))
      |-> (hit_o == (cur_ovt & ~cur_mask)));

endmodule

bind bhc_top bhc_top_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xing_i      (xing_i),
  .over_thr_i  (over_thr_i),
  .mode_i      (mode_i),
  .mask_i      (mask_i),
  .hit_o       (hit_o),
  .hit_valid_o (hit_valid_o)
);

// File: tb/sim_bhc_top.sv
module sim_bhc_top;
  localparam int  NUM_CH     = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              xing_i = 1'b0;
  logic [NUM_CH-1:0] over_thr_i = '0;
  logic              mode_i = 1'b0;
  logic [NUM_CH-1:0] mask_i = '0;
  logic [NUM_CH-1:0] hit_o;
  logic              hit_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bhc_top #(.NUM_CH(NUM_CH)) u0 (
    .clk, .rst_n, .xing_i, .over_thr_i, .mode_i, .mask_i, .hit_o, .hit_valid_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one crossing: drive at falling edge, sample output one cycle later
  task automatic crossing(input logic [NUM_CH-1:0] ovt, input logic md,
                          input logic [NUM_CH-1:0] mk, input logic [NUM_CH-1:0] exp,
                          input string tag);
    @(negedge clk);
    over_thr_i = ovt; mode_i = md; mask_i = mk; xing_i = 1'b1;
    @(negedge clk);
    xing_i = 1'b0;
    check({tag, " valid"}, 32'(hit_valid_o), 32'd1);
    check({tag, " hits"}, 32'(hit_o), 32'(exp));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset valid", 32'(hit_valid_o), 32'd0);
    check("R1 reset hits", 32'(hit_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", 32'(hit_valid_o), 32'd0);
  endtask

  task automatic t_track();
    crossing(8'h5A, 1'b0, 8'h00, 8'h5A, "R4 track a");
    crossing(8'h5A, 1'b0, 8'h00, 8'h5A, "R4 track held");
    crossing(8'h81, 1'b0, 8'h00, 8'h81, "R4 track b");
  endtask

  task automatic t_spacing();
    crossing(8'hFF, 1'b0, 8'h00, 8'hFF, "R2 crossing");
    @(negedge clk);
    check("R2 valid low after", 32'(hit_valid_o), 32'd0);
    check("R3 no spill", 32'(hit_o), 32'd0);
    crossing(8'h00, 1'b0, 8'h00, 8'h00, "R3 empty crossing");
  endtask

  task automatic t_pulse();
    crossing(8'h03, 1'b1, 8'h00, 8'h03, "R5 pulse first");
    crossing(8'h03, 1'b1, 8'h00, 8'h00, "R6 dead held");
    crossing(8'h03, 1'b1, 8'h00, 8'h03, "R5 alternate");
    crossing(8'h04, 1'b1, 8'h00, 8'h04, "R6 live other ch");
    crossing(8'h07, 1'b1, 8'h00, 8'h03, "R6 dead ignores ch2");
    crossing(8'h00, 1'b1, 8'h00, 8'h00, "R5 quiet");
    crossing(8'h07, 1'b1, 8'h00, 8'h07, "R6 live again");
  endtask

  task automatic t_mask();
    crossing(8'hFF, 1'b0, 8'h0F, 8'hF0, "R7 track mask");
    crossing(8'hFF, 1'b1, 8'hF0, 8'h0F, "R7 pulse mask");
    crossing(8'h00, 1'b1, 8'hF0, 8'h00, "R7 settle");
  endtask

  task automatic t_ctrl_clear();
    crossing(8'h01, 1'b1, 8'h00, 8'h01, "R8 set");
    crossing(8'h01, 1'b1, 8'h00, 8'h00, "R8 dead");
    crossing(8'h01, 1'b1, 8'h00, 8'h01, "R8 hit");
    crossing(8'h01, 1'b1, 8'h80, 8'h01, "R8 mask change clears");
    crossing(8'h01, 1'b1, 8'h80, 8'h00, "R8 dead after");
  endtask

  task automatic t_between();
    crossing(8'h00, 1'b0, 8'h00, 8'h00, "R9 base");
    @(negedge clk);
    over_thr_i = 8'hFF; mode_i = 1'b1; mask_i = 8'hFF;
    @(negedge clk);
    check("R9 no valid between", 32'(hit_valid_o), 32'd0);
    over_thr_i = 8'h00;
    @(negedge clk);
    check("R9 hits between", 32'(hit_o), 32'd0);
    crossing(8'h00, 1'b0, 8'h00, 8'h00, "R9 after activity");
    crossing(8'h22, 1'b0, 8'h00, 8'h22, "R9 track intact");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_track();
    t_spacing();
    t_pulse();
    t_mask();
    t_ctrl_clear();
    t_between();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule